// File: doc/BRIEF.md
# Three-Group Interrupt Status Encoder

This block collects interrupt requests from three groups: a small critical group, a main group and a peripheral group. It samples all requests into a register every clock. It masks the main and peripheral requests with software-written disable bits. It then forms one 32-bit status word. Each group owns a flag and a code field in that word, and the code names the winning source of that group. Software reads the word and takes the first group whose flag is set, in the order critical, then main, then peripheral.

Each peripheral source can be promoted by a two-bit boost setting. A high boost makes the request appear in the critical field as reserved code 2. A medium boost makes it appear in the main field as reserved code 4. In both cases the peripheral field still names the real source, so a handler that sees a reserved code goes on to read the peripheral field.

Software reaches the masks, the boost settings and the status word through a small word-addressed register port. Writes take effect on the clock edge. Reads are combinational.

Top module: `irq_status_encoder`

## Requirements
- R1: After reset the main mask reads 0x0001FFFF, the peripheral mask reads 0xFFFFFC00, both boost registers read 0 and the status word is 0. With these masks every main and peripheral source is disabled.
- R2: Critical inputs crit_req[0], crit_req[1] and crit_req[2] report codes 0, 1 and 3. The lowest-indexed pending input wins. A critical request sets bit 10 and puts its code in bits 9:8. Critical inputs cannot be masked. A request sampled at one rising edge is visible in the status word right after that edge.
- R3: An unmasked main request sets bit 21 and puts the lowest pending source number in bits 20:16. Main source 4 is reserved, and its request input is ignored.
- R4: An unmasked peripheral request sets bit 29 and puts the lowest pending source number in bits 28:24, unless a boosted source takes the field (R6, R7).
- R5: Main source n is disabled by bit (16-n) of the main mask. Peripheral source n is disabled by bit (31-n) of the peripheral mask. A 1 disables the source. A mask write changes the status word right after its write edge.
- R6: A peripheral source with boost value 2 (high) that is pending and unmasked puts code 2 in the critical field when no critical input is pending. The critical flag is set whenever such a request is pending. The peripheral field then shows the lowest such high-boost source.
- R7: A peripheral source with boost value 1 (medium) that is pending and unmasked puts code 4 in the main field when no main request is pending, and sets the main flag. If no high-boost request is pending, the peripheral field shows the lowest such medium-boost source. Boost values 0 and 3 both mean no boost.
- R8: A code field whose flag is clear reads 0. All status bits outside the three flags and three codes read 0.
- R9: The register addresses are: 0 status (read only, writes ignored), 1 main mask, 2 peripheral mask, 3 boost for sources 0 to 15, 4 boost for sources 16 to 21. Source n's boost sits in bits 2n+1:2n of register 3, or in bits 2(n-16)+1:2(n-16) of register 4. Bits that belong to no source read 0. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crit_req | input | 3 | Critical group requests |
| main_req | input | MAIN_N (17) | Main group requests, one per source |
| per_req | input | PER_N (22) | Peripheral group requests, one per source |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| status_word | output | 32 | Encoded status word |

## Verification
The bench drives single requests and groups of requests so that the lowest-index rule can be told apart from other selection orders. It uses critical patterns that skip code 2, and a main pattern that holds only the reserved source 4. Mask patterns with single set bits show whether the reversed bit mapping (16-n and 31-n) is honoured and not a direct mapping. Boost patterns mix high, medium, value-3 and unboosted sources, with and without native critical or main requests, so that the reserved codes, the order of the peripheral field and the rule that real requests beat promoted ones are each checked alone.

// File: rtl/irq_status_encoder.sv
module irq_status_encoder #(
  parameter int MAIN_N = 17,
  parameter int PER_N  = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        crit_req,
  input  logic [MAIN_N-1:0] main_req,
  input  logic [PER_N-1:0]  per_req,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [31:0]       status_word
);

  function automatic logic [31:0] main_impl_f();
    main_impl_f = '0;
    for (int n = 0; n < MAIN_N; n++) main_impl_f[16-n] = 1'b1;
  endfunction

  function automatic logic [31:0] per_impl_f();
    per_impl_f = '0;
    for (int n = 0; n < PER_N; n++) per_impl_f[31-n] = 1'b1;
  endfunction

  function automatic logic [63:0] boost_impl_f();
    boost_impl_f = '0;
    for (int n = 0; n < PER_N; n++) boost_impl_f[2*n +: 2] = 2'b11;
  endfunction

  function automatic logic [5:0] first_set(input logic [31:0] v);
    first_set = '0;
    for (int i = 31; i >= 0; i--)
      if (v[i]) first_set = {1'b1, i[4:0]};
  endfunction

  localparam logic [31:0] MAIN_IMPL  = main_impl_f();
  localparam logic [31:0] PER_IMPL   = per_impl_f();
  localparam logic [63:0] BOOST_IMPL = boost_impl_f();
  localparam logic [2:0]  A_STATUS = 3'd0, A_MMASK = 3'd1, A_PMASK = 3'd2,
                          A_BLO = 3'd3, A_BHI = 3'd4;

  logic [2:0]        crit_q;
  logic [MAIN_N-1:0] main_q;
  logic [PER_N-1:0]  per_q;
  logic [31:0]       main_mask, per_mask;
  logic [63:0]       boost;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crit_q    <= '0;
      main_q    <= '0;
      per_q     <= '0;
      main_mask <= MAIN_IMPL;
      per_mask  <= PER_IMPL;
      boost     <= '0;
    end else begin
      crit_q <= crit_req;
      main_q <= main_req;
      per_q  <= per_req;
      if (bus_we) begin
        case (bus_addr)
          A_MMASK: main_mask      <= bus_wdata & MAIN_IMPL;
          A_PMASK: per_mask       <= bus_wdata & PER_IMPL;
          A_BLO:   boost[31:0]    <= bus_wdata & BOOST_IMPL[31:0];
          A_BHI:   boost[63:32]   <= bus_wdata & BOOST_IMPL[63:32];
          default: ;
        endcase
      end
    end
  end

  logic [31:0] main_act, per_hi, per_med, per_norm;

  always_comb begin
    main_act = '0;
    per_hi   = '0;
    per_med  = '0;
    per_norm = '0;
    for (int n = 0; n < MAIN_N; n++)
      main_act[n] = main_q[n] & ~main_mask[16-n];
    main_act[4] = 1'b0;
    for (int n = 0; n < PER_N; n++) begin
      if (per_q[n] && !per_mask[31-n]) begin
        case (boost[2*n +: 2])
          2'd2:    per_hi[n]   = 1'b1;
          2'd1:    per_med[n]  = 1'b1;
          default: per_norm[n] = 1'b1;
        endcase
      end
    end
  end

  logic [5:0] main_sel, hi_sel, med_sel, norm_sel;
  assign main_sel = first_set(main_act);
  assign hi_sel   = first_set(per_hi);
  assign med_sel  = first_set(per_med);
  assign norm_sel = first_set(per_norm);

  logic       crit_flag, main_flag, per_flag;
  logic [1:0] crit_code;
  logic [4:0] main_code, per_code;

  assign crit_flag = (|crit_q) | hi_sel[5];
  assign crit_code = crit_q[0] ? 2'd0 :
                     crit_q[1] ? 2'd1 :
                     crit_q[2] ? 2'd3 :
                     hi_sel[5] ? 2'd2 : 2'd0;

  assign main_flag = main_sel[5] | med_sel[5];
  assign main_code = main_sel[5] ? main_sel[4:0] :
                     med_sel[5]  ? 5'd4 : 5'd0;

  assign per_flag = hi_sel[5] | med_sel[5] | norm_sel[5];
  assign per_code = hi_sel[5]   ? hi_sel[4:0]  :
                    med_sel[5]  ? med_sel[4:0] :
                    norm_sel[5] ? norm_sel[4:0] : 5'd0;

  assign status_word = {2'b00, per_flag, per_code, 2'b00, main_flag, main_code,
                        5'b0, crit_flag, crit_code, 8'h00};

  always_comb begin
    case (bus_addr)
      A_STATUS: bus_rdata = status_word;
      A_MMASK:  bus_rdata = main_mask;
      A_PMASK:  bus_rdata = per_mask;
      A_BLO:    bus_rdata = boost[31:0];
      A_BHI:    bus_rdata = boost[63:32];
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_status_encoder_chk.sv
module irq_status_encoder_chk #(
  parameter int MAIN_N = 17,
  parameter int PER_N  = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        crit_req,
  input logic [PER_N-1:0]  per_req,
  input logic              bus_we,
  input logic [2:0]        bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       status_word,
  input logic [31:0]       main_mask
);

  localparam logic [31:0] FIELD_BITS = 32'h3F3F_0700;

  a_r2_crit_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (|$past(crit_req))) |-> status_word[10]);

  a_r2_crit_code0: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(crit_req[0])) |-> (status_word[9:8] == 2'd0));

  a_r4_per_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(per_req) == '0)) |-> !status_word[29]);

  a_r6_hi_code_has_per: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[10] && status_word[9:8] == 2'd2) |-> status_word[29]);

  a_r7_med_code_has_per: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[21] && status_word[20:16] == 5'd4) |-> status_word[29]);

  a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word & ~FIELD_BITS) == 32'h0);

  a_r8_codes_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_word[10] |-> status_word[9:8] == 2'd0) and
    (!status_word[21] |-> status_word[20:16] == 5'd0) and
    (!status_word[29] |-> status_word[28:24] == 5'd0));

  a_r9_main_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd1) |=> (main_mask == ($past(bus_wdata) & 32'h0001_FFFF)));

endmodule

bind irq_status_encoder irq_status_encoder_chk #(.MAIN_N(MAIN_N), .PER_N(PER_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .crit_req(crit_req), .per_req(per_req),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .status_word(status_word), .main_mask(main_mask)
);

// File: tb/tb_irq_status_encoder.sv
module tb_irq_status_encoder;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  crit_req = '0;
  logic [16:0] main_req = '0;
  logic [21:0] per_req = '0;
  logic        bus_we = 0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, status_word;
  int checks = 0, failures = 0;

  irq_status_encoder dut (.*);

  always #4 clk = ~clk;

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(string req, logic [2:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1 chk(req, bus_rdata, exp);
  endtask

  task automatic apply(logic [2:0] c, logic [16:0] m, logic [21:0] p);
    @(negedge clk);
    crit_req = c; main_req = m; per_req = p;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 status", status_word, 32'h0);
    rd("R1 main mask", 3'd1, 32'h0001_FFFF);
    rd("R1 per mask", 3'd2, 32'hFFFF_FC00);
    rd("R1 boost lo", 3'd3, 32'h0);
    rd("R1 boost hi", 3'd4, 32'h0);
    apply(3'b000, '1, '1);
    chk("R5 reset masks disable all", status_word, 32'h0);
    apply(3'b000, '0, '0);
  endtask

  task automatic t_crit();
    apply(3'b110, '0, '0);
    chk("R2 timer wins", status_word, 32'h0000_0500);
    apply(3'b100, '0, '0);
    chk("R2 wake code 3", status_word, 32'h0000_0700);
    apply(3'b111, '0, '0);
    chk("R2 ext0 wins", status_word, 32'h0000_0400);
    apply(3'b000, '0, '0);
    chk("R8 idle", status_word, 32'h0);
  endtask

  task automatic t_main();
    wr(3'd1, 32'h0);
    apply(3'b000, 17'h00210, '0);
    chk("R3 lowest main", status_word, 32'h0029_0000);
    apply(3'b000, 17'h00010, '0);
    chk("R3 source 4 ignored", status_word, 32'h0);
    apply(3'b000, 17'h00201, '0);
    chk("R3 source 0", status_word, 32'h0020_0000);
    wr(3'd1, 32'h0001_0000);
    chk("R5 main bit16 masks source 0", status_word, 32'h0029_0000);
  endtask

  task automatic t_per();
    wr(3'd2, 32'h0);
    apply(3'b000, '0, 22'h0000A0);
    chk("R4 lowest per", status_word, 32'h2500_0000);
    wr(3'd2, 32'h0400_0000);
    chk("R5 per bit26 masks source 5", status_word, 32'h2700_0000);
    wr(3'd2, 32'h0);
    apply(3'b010, 17'h00200, 22'h000080);
    chk("R2 R3 R4 all fields", status_word, 32'h2729_0500);
    apply(3'b000, '0, '0);
  endtask

  task automatic t_boost();
    wr(3'd3, 32'h0200_0000);
    apply(3'b000, '0, 22'h001008);
    chk("R6 high boost", status_word, 32'h2C00_0600);
    apply(3'b001, '0, 22'h001008);
    chk("R6 native crit beats boost", status_word, 32'h2C00_0400);
    wr(3'd3, 32'h0000_00C0);
    wr(3'd4, 32'h0000_0100);
    apply(3'b000, '0, 22'h100008);
    chk("R7 medium boost", status_word, 32'h3424_0000);
    apply(3'b000, 17'h00020, 22'h100008);
    chk("R7 main request beats boost", status_word, 32'h3425_0000);
    apply(3'b000, '0, 22'h000008);
    chk("R7 boost value 3 is normal", status_word, 32'h2300_0000);
    apply(3'b000, '0, '0);
  endtask

  task automatic t_regs();
    wr(3'd1, 32'hFFFF_FFFF);
    rd("R9 main mask impl bits", 3'd1, 32'h0001_FFFF);
    wr(3'd4, 32'hFFFF_FFFF);
    rd("R9 boost hi impl bits", 3'd4, 32'h0000_0FFF);
    wr(3'd0, 32'hFFFF_FFFF);
    rd("R9 status write ignored", 3'd0, 32'h0);
    rd("R9 unmapped reads 0", 3'd7, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_crit();
    t_main();
    t_per();
    t_boost();
    t_regs();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule